// File: doc/BRIEF.md
# Adaptive Compression Policy Counter

This block keeps a running tally of whether compressing lines in a second-level cache is paying off. A classifier upstream sends one reference event per cycle at most. A hit that had to pay for decompression counts against compression. A miss that compression removed, or could have removed, counts for it. Each event moves a signed saturating score by a cycle cost set in software: the decompression penalty for a slow hit and the miss penalty for a saved miss. A typical pair is 5 and 400 cycles. All other events leave the score alone.

Only the sign of the score sets the policy, with no threshold involved. A score of zero or above means compress, and a negative score means store uncompressed. When the cache allocates a line it pulses `alloc`. One cycle later the block returns a registered decision, taken from the score as it stood before that edge.

Top module: `comp_policy_ctr`

## Requirements
- R1: After synchronous reset, `score` is 0, `comp_en` is 1 and `alloc_vld` is 0.
- R2: An accepted event with `ev_code` = 2 (slow hit) lowers `score` by `dec_cost`.
- R3: An accepted event with `ev_code` = 3 (miss saved) or 4 (miss savable) raises `score` by `miss_cost`.
- R4: `score` does not change when `ev_valid` is 0, or when `ev_code` is 0, 1 (plain hit), 5 (hard miss), 6 or 7.
- R5: With the default width of 19 bits, `score` is clamped at +262143 and does not wrap to a negative value.
- R6: With the default width, `score` is clamped at -262144 and does not wrap to a positive value.
- R7: `comp_en` is 1 when `score` is zero or positive and 0 when it is negative.
- R8: `alloc` in cycle n gives `alloc_vld` = 1 in cycle n+1. In that cycle `alloc_comp` equals `comp_en` as it was in cycle n, and an event in cycle n does not affect it. Without `alloc`, `alloc_vld` is 0.
- R9: An event sampled at one clock edge shows on `score` and `comp_en` right after that edge. Events on consecutive cycles all take effect, with none lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | A reference event is present this cycle |
| ev_code | input | 3 | Event class: 0 none, 1 plain hit, 2 slow hit, 3 miss saved, 4 miss savable, 5 hard miss |
| dec_cost | input | PEN_W (16) | Decompression penalty in cycles, unsigned |
| miss_cost | input | PEN_W (16) | Miss penalty in cycles, unsigned |
| alloc | input | 1 | The cache is allocating a line this cycle |
| score | output | CTR_W (19) | Signed two's-complement score, registered |
| comp_en | output | 1 | Current policy: 1 means compress |
| alloc_vld | output | 1 | An allocation decision is valid this cycle |
| alloc_comp | output | 1 | Decision for that allocation: 1 means store compressed |

## Verification
The bench steps the score down from +800 to exactly zero, and then one step more, so that a design treating zero as negative, or testing the wrong bit, shows up at the sign flip. It drives the largest penalties until the score reaches each rail and then keeps pushing. A design without clamping would wrap to the opposite sign and reverse the policy. Every neutral code is sent with `ev_valid` high, and a slow-hit code is sent with `ev_valid` low, to catch decoders that ignore the valid bit or match too broadly. An allocation issued in the same cycle as a sign-flipping event checks that the decision uses the score from before that event.

// File: rtl/comp_policy_pkg.sv
package comp_policy_pkg;

  // Reference classes presented by the upstream classifier.
  localparam logic [2:0] EV_IDLE         = 3'd0;
  localparam logic [2:0] EV_HIT_PLAIN    = 3'd1;
  localparam logic [2:0] EV_HIT_SLOW     = 3'd2;
  localparam logic [2:0] EV_MISS_SAVED   = 3'd3;
  localparam logic [2:0] EV_MISS_SAVABLE = 3'd4;
  localparam logic [2:0] EV_MISS_HARD    = 3'd5;

  localparam int DEF_CTR_W = 19;
  localparam int DEF_PEN_W = 16;

endpackage

// File: rtl/cpc_delta.sv
// Turns one classified reference into a signed step for the score.
module cpc_delta
  import comp_policy_pkg::*;
#(
  parameter int CW = DEF_CTR_W,
  parameter int PW = DEF_PEN_W
) (
  input  logic                 valid,
  input  logic [2:0]           code,
  input  logic [PW-1:0]        dec_cost,
  input  logic [PW-1:0]        miss_cost,
  output logic signed [CW:0]   delta
);

  localparam int PAD = CW + 1 - PW;

  logic signed [CW:0] dec_ext;
  logic signed [CW:0] miss_ext;

  assign dec_ext  = $signed({{PAD{1'b0}}, dec_cost});
  assign miss_ext = $signed({{PAD{1'b0}}, miss_cost});

  always_comb begin
    delta = '0;
    if (valid) begin
      case (code)
        EV_HIT_SLOW:     delta = -dec_ext;
        EV_MISS_SAVED,
        EV_MISS_SAVABLE: delta = miss_ext;
        default:         delta = '0;
      endcase
    end
  end

endmodule

// File: rtl/cpc_sat_acc.sv
// Signed accumulator with a guard bit; clamps to the rails on overflow.
module cpc_sat_acc #(
  parameter int CW = 19
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [CW:0]   delta,
  output logic signed [CW-1:0] acc_q
);

  localparam logic signed [CW-1:0] RAIL_HI = {1'b0, {(CW-1){1'b1}}};
  localparam logic signed [CW-1:0] RAIL_LO = {1'b1, {(CW-1){1'b0}}};

  logic signed [CW:0]   sum;
  logic signed [CW-1:0] acc_d;

  assign sum = {acc_q[CW-1], acc_q} + delta;

  always_comb begin
    if (sum[CW] != sum[CW-1]) begin
      acc_d = sum[CW] ? RAIL_LO : RAIL_HI;
    end else begin
      acc_d = sum[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/cpc_alloc_gate.sv
// Samples the policy for each line allocation.
module cpc_alloc_gate (
  input  logic clk,
  input  logic rst,
  input  logic sign_bit,
  input  logic alloc,
  output logic policy,
  output logic alloc_vld_q,
  output logic alloc_comp_q
);

  assign policy = ~sign_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      alloc_vld_q  <= 1'b0;
      alloc_comp_q <= 1'b0;
    end else begin
      alloc_vld_q  <= alloc;
      alloc_comp_q <= alloc ? policy : 1'b0;
    end
  end

endmodule

// File: rtl/comp_policy_ctr.sv
module comp_policy_ctr
  import comp_policy_pkg::*;
#(
  parameter int CTR_W = DEF_CTR_W,  // score width, signed
  parameter int PEN_W = DEF_PEN_W   // penalty width, must be below CTR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_valid,
  input  logic [2:0]       ev_code,
  input  logic [PEN_W-1:0] dec_cost,
  input  logic [PEN_W-1:0] miss_cost,
  input  logic             alloc,
  output logic [CTR_W-1:0] score,
  output logic             comp_en,
  output logic             alloc_vld,
  output logic             alloc_comp
);

  logic signed [CTR_W:0]   step;
  logic signed [CTR_W-1:0] acc;

  cpc_delta #(.CW(CTR_W), .PW(PEN_W)) u_delta (
    .valid     (ev_valid),
    .code      (ev_code),
    .dec_cost  (dec_cost),
    .miss_cost (miss_cost),
    .delta     (step)
  );

  cpc_sat_acc #(.CW(CTR_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .delta (step),
    .acc_q (acc)
  );

  cpc_alloc_gate u_gate (
    .clk          (clk),
    .rst          (rst),
    .sign_bit     (acc[CTR_W-1]),
    .alloc        (alloc),
    .policy       (comp_en),
    .alloc_vld_q  (alloc_vld),
    .alloc_comp_q (alloc_comp)
  );

  assign score = acc;

endmodule

// File: rtl/comp_policy_ctr_chk.sv
module comp_policy_ctr_chk
  import comp_policy_pkg::*;
#(
  parameter int CW = DEF_CTR_W
) (
  input logic          clk,
  input logic          rst,
  input logic          ev_valid,
  input logic [2:0]    ev_code,
  input logic          alloc,
  input logic [CW-1:0] score,
  input logic          comp_en,
  input logic          alloc_vld,
  input logic          alloc_comp
);

  localparam logic signed [CW-1:0] RAIL_HI = {1'b0, {(CW-1){1'b1}}};

  logic moving;
  logic slow_hit;
  logic saved_miss;
  assign slow_hit   = ev_valid && (ev_code == EV_HIT_SLOW);
  assign saved_miss = ev_valid && (ev_code == EV_MISS_SAVED || ev_code == EV_MISS_SAVABLE);
  assign moving     = slow_hit || saved_miss;

  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (score == '0 && comp_en && !alloc_vld));

  a_r2_slow_no_rise: assert property (@(posedge clk) disable iff (rst)
    slow_hit |=> ($signed(score) <= $signed($past(score))));

  a_r3_miss_no_fall: assert property (@(posedge clk) disable iff (rst)
    saved_miss |=> ($signed(score) >= $signed($past(score))));

  a_r4_neutral_hold: assert property (@(posedge clk) disable iff (rst)
    !moving |=> $stable(score));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    ($signed(score) == RAIL_HI && saved_miss) |=> ($signed(score) == RAIL_HI));

  a_r8_alloc_sample: assert property (@(posedge clk) disable iff (rst)
    alloc |=> (alloc_vld && alloc_comp == $past(comp_en)));

  a_r8_vld_pulse: assert property (@(posedge clk) disable iff (rst)
    !alloc |=> !alloc_vld);

endmodule

bind comp_policy_ctr comp_policy_ctr_chk #(.CW(CTR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ev_valid   (ev_valid),
  .ev_code    (ev_code),
  .alloc      (alloc),
  .score      (score),
  .comp_en    (comp_en),
  .alloc_vld  (alloc_vld),
  .alloc_comp (alloc_comp)
);

// File: tb/comp_policy_ctr_test.sv
module comp_policy_ctr_test;

  localparam int CW = 19;
  localparam int PW = 16;
  localparam int HI = 262143;
  localparam int LO = -262144;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ev_valid = 1'b0;
  logic [2:0]    ev_code = 3'd0;
  logic [PW-1:0] dec_cost = '0;
  logic [PW-1:0] miss_cost = '0;
  logic          alloc = 1'b0;
  logic [CW-1:0] score;
  logic          comp_en;
  logic          alloc_vld;
  logic          alloc_comp;

  always #4 clk = ~clk;  // 125 MHz

  comp_policy_ctr uut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_code(ev_code),
    .dec_cost(dec_cost), .miss_cost(miss_cost), .alloc(alloc),
    .score(score), .comp_en(comp_en), .alloc_vld(alloc_vld), .alloc_comp(alloc_comp)
  );

  typedef struct {
    string tag;
    int    sc;
    bit    ce;
    bit    av;
    bit    ac;
  } exp_t;

  exp_t q[$];
  int   n_vec  = 0;
  int   n_bad  = 0;
  int   m_sc   = 0;
  bit   done   = 1'b0;

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic drive(input bit v, input logic [2:0] c, input bit al,
                       input int dc, input int mc, input string tag);
    exp_t e;
    @(negedge clk);
    ev_valid  = v;
    ev_code   = c;
    alloc     = al;
    dec_cost  = dc[PW-1:0];
    miss_cost = mc[PW-1:0];
    e.tag = tag;
    e.av  = al;
    e.ac  = al && (m_sc >= 0);
    if (v && c == 3'd2) m_sc = m_sc - dc;
    if (v && (c == 3'd3 || c == 3'd4)) m_sc = m_sc + mc;
    if (m_sc > HI) m_sc = HI;
    if (m_sc < LO) m_sc = LO;
    e.sc = m_sc;
    e.ce = (m_sc >= 0);
    q.push_back(e);
  endtask

  // Monitor: compares each queued item just after the edge that produces it.
  always @(posedge clk) begin
    exp_t e;
    int   act;
    #2;
    if (!rst && q.size() > 0) begin
      e   = q.pop_front();
      act = int'($signed(score));
      n_vec++;
      if (act != e.sc || comp_en != e.ce || alloc_vld != e.av || alloc_comp != e.ac) begin
        n_bad++;
        $display("FAIL %s: score=%0d comp_en=%0b alloc_vld=%0b alloc_comp=%0b, expected %0d %0b %0b %0b",
                 e.tag, act, comp_en, alloc_vld, alloc_comp, e.sc, e.ce, e.av, e.ac);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (score != '0 || comp_en != 1'b1 || alloc_vld != 1'b0) begin
      n_bad++;
      $display("FAIL R1: score=%0d comp_en=%0b alloc_vld=%0b, expected 0 1 0",
               int'($signed(score)), comp_en, alloc_vld);
    end
    rst = 1'b0;

    // R7: zero counts as enable; R8 allocation at zero
    drive(1'b0, 3'd0, 1'b1, 5, 400, "R7_zero_alloc");
    // R3: both saved-miss classes add the miss penalty
    drive(1'b1, 3'd3, 1'b0, 5, 400, "R3_saved");
    drive(1'b1, 3'd4, 1'b0, 5, 400, "R3_savable");
    // R2: slow hits walk the score back to exactly zero
    for (int i = 0; i < 160; i++) drive(1'b1, 3'd2, (i == 159), 5, 400, "R2_slow");
    drive(1'b0, 3'd0, 1'b1, 5, 400, "R7_exact_zero");
    drive(1'b1, 3'd2, 1'b0, 5, 400, "R7_goes_negative");
    // R4: neutral classes and invalid events
    drive(1'b1, 3'd1, 1'b0, 5, 400, "R4_plain_hit");
    drive(1'b1, 3'd5, 1'b0, 5, 400, "R4_hard_miss");
    drive(1'b1, 3'd0, 1'b0, 5, 400, "R4_code0");
    drive(1'b1, 3'd6, 1'b0, 5, 400, "R4_code6");
    drive(1'b1, 3'd7, 1'b0, 5, 400, "R4_code7");
    drive(1'b0, 3'd2, 1'b0, 5, 400, "R4_invalid_slow");
    drive(1'b0, 3'd3, 1'b0, 5, 400, "R4_invalid_miss");
    // R8: allocation in the same cycle as a sign flip uses the old sign
    drive(1'b1, 3'd3, 1'b1, 5, 400, "R8_alloc_pre_event");
    drive(1'b1, 3'd2, 1'b1, 400, 400, "R8_alloc_pre_event2");
    drive(1'b0, 3'd0, 1'b1, 5, 400, "R8_alloc_after");
    // R5: push to the upper rail and beyond
    for (int i = 0; i < 7; i++) drive(1'b1, 3'd3, 1'b0, 5, 65535, "R5_rail_hi");
    drive(1'b1, 3'd4, 1'b1, 5, 65535, "R5_hold_hi");
    // R6: push to the lower rail and beyond
    for (int i = 0; i < 10; i++) drive(1'b1, 3'd2, 1'b0, 65535, 400, "R6_rail_lo");
    drive(1'b1, 3'd2, 1'b1, 65535, 400, "R6_hold_lo");
    drive(1'b1, 3'd3, 1'b0, 5, 1, "R6_leave_lo");
    // R9: back-to-back events with changing costs
    drive(1'b1, 3'd3, 1'b0, 7, 300, "R9_b2b_a");
    drive(1'b1, 3'd2, 1'b0, 7, 300, "R9_b2b_b");
    drive(1'b1, 3'd4, 1'b0, 9, 65535, "R9_b2b_c");
    drive(1'b1, 3'd2, 1'b1, 123, 1, "R9_b2b_d");
    drive(1'b0, 3'd0, 1'b0, 0, 0, "R9_flush");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule